// File: doc/BRIEF.md
# Palette and Frame Load Sequencer

This block stands between a 32-bit word stream and the pixel input of an LCD pipeline. It takes in a color palette, records the pixel depth the palette announces, and then streams frame pixels. In the indexed depths each pixel is looked up in an on-chip palette RAM of 12-bit colors. At 16 bits per pixel the palette is skipped and pixels pass straight through. Memory addressing, DMA and raster timing are handled elsewhere.

The sequencer runs while `enable` is high. When `enable` rises it samples the load mode, which selects one of three jobs. It can load the palette alone and then stop. It can stream a frame using the palette and depth that are already held. It can load the palette and then stream the frame. The pixel depth is never set directly. It comes from a code nibble inside the first palette word, and the palette region size, and so the transfer length, follow from that code. A palette-loaded flag reports the end of a palette transfer. How that flag may be cleared depends on the mode.

Top module: `lcd_load_seq`

## Requirements
- R1: `load_mode` is sampled when the sequencer starts from idle with `enable` high: 0 = palette only, 1 = frame only, 2 = palette then frame; 3 is reserved and leaves the sequencer idle with `in_ready` low.
- R2: The depth code is bits [15:12] of the first palette word (0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 4 and above = 16 bpp). The region holds 256 entries for code 3, 16 entries for code 4 and above, and 128 entries otherwise. The transfer length is region entries / 2 + 1 words.
- R3: Each palette word supplies two entries, bits [15:0] first and bits [31:16] second, at consecutive indexes starting from 0. The color stored is the low 12 bits of each half. Entries at or beyond the region size, including both halves of the trailing extra word, are not written.
- R4: `pal_loaded` rises on the clock edge that accepts the last palette word. In palette-only mode `in_ready` then stays low until `enable` drops.
- R5: A high `pal_clr` clears `pal_loaded` only in palette-only mode. In the other modes it has no effect.
- R6: Within one cycle of `enable` going low, `in_ready`, `pix_valid` and `pal_loaded` are all low. The depth code and the palette contents are kept.
- R7: In the indexed depths each frame word is split into 32/bpp fields, least significant field first. The palette entry each field selects is output as `{4'h0, color}`, registered one cycle after the word is taken.
- R8: At 16 bpp each frame word gives two pixels, bits [15:0] first, passed through unchanged.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_data` holds its value and `in_ready` is low.
- R10: After reset `in_ready`, `pix_valid` and `pal_loaded` are low and the depth code is 16 bpp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the sequencer; low returns it to idle |
| load_mode | input | 2 | Job selected on start |
| pal_clr | input | 1 | Request to clear the palette-loaded flag |
| in_data | input | 32 | Input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| pix_ready | input | 1 | Downstream ready for a pixel |
| pix_valid | output | 1 | Pixel valid |
| pix_data | output | 16 | Pixel value |
| pal_loaded | output | 1 | Palette transfer complete |

## Verification
The bench aims at the trailing extra palette word. If it were written with a truncated index it would overwrite entries 0 and 1, and the 8-bpp pixels that select those entries would come out with the wrong colors. It also checks the word count for each depth code by watching the flag stay low before the last word and go high after it. It checks that `pal_clr` is ignored outside palette-only mode, where a broken design would drop the flag early. Random stalls on the pixel side would show any design that changes held data or takes a new word while blocked. A frame-only run with no palette load, and another after a disable, confirm that the depth code resets to 16 bpp and is kept across a disable.

// File: rtl/lcdseq_pkg.sv
`timescale 1ns/1ps
package lcdseq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PAL   = 2'd1,
        SQ_FRAME = 2'd2,
        SQ_HOLD  = 2'd3
    } sq_state_e;

    localparam logic [1:0] LM_PAL   = 2'd0;
    localparam logic [1:0] LM_FRAME = 2'd1;
    localparam logic [1:0] LM_BOTH  = 2'd2;

    localparam logic [3:0] BPP_CODE_8  = 4'd3;
    localparam logic [3:0] BPP_CODE_16 = 4'd4;
endpackage

// File: rtl/lcdseq_pal_sizer.sv
`timescale 1ns/1ps
module lcdseq_pal_sizer #(
    parameter int PAL_DEPTH     = 256,
    parameter int SMALL_ENTRIES = 16,
    parameter int CNT_W         = 9
) (
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] kept,
    output logic [CNT_W-1:0] words
);
    import lcdseq_pkg::*;

    localparam logic [CNT_W-1:0] FULL_N  = CNT_W'(PAL_DEPTH);
    localparam logic [CNT_W-1:0] HALF_N  = CNT_W'(PAL_DEPTH / 2);
    localparam logic [CNT_W-1:0] SMALL_N = CNT_W'(SMALL_ENTRIES);

    always_comb begin
        if (code == BPP_CODE_8)       kept = FULL_N;
        else if (code >= BPP_CODE_16) kept = SMALL_N;
        else                          kept = HALF_N;
        words = (kept >> 1) + CNT_W'(1);
    end
endmodule

// File: rtl/lcdseq_pal_ram.sv
`timescale 1ns/1ps
module lcdseq_pal_ram #(
    parameter int DEPTH   = 256,
    parameter int COLOR_W = 12,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we_a,
    input  logic [AW-1:0]      addr_a,
    input  logic [COLOR_W-1:0] data_a,
    input  logic               we_b,
    input  logic [AW-1:0]      addr_b,
    input  logic [COLOR_W-1:0] data_b,
    input  logic [AW-1:0]      raddr,
    output logic [COLOR_W-1:0] rdata
);
    logic [COLOR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= data_a;
        if (we_b) mem[addr_b] <= data_b;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lcdseq_unpack.sv
`timescale 1ns/1ps
module lcdseq_unpack #(
    parameter int WORD_W = 32,
    parameter int PIX_W  = 16,
    parameter int AW     = 8,
    parameter int SLOT_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SLOT_W-1:0] slot,
    input  logic [3:0]        code,
    output logic [AW-1:0]     index,
    output logic [PIX_W-1:0]  raw,
    output logic              direct,
    output logic              last
);
    import lcdseq_pkg::*;

    localparam int PIX_LG = $clog2(PIX_W);
    localparam int LG_W   = $clog2(PIX_LG + 1);
    localparam logic [SLOT_W:0] PPW_MAX = (SLOT_W + 1)'(WORD_W);

    logic [LG_W-1:0]   lg;
    logic [SLOT_W-1:0] shamt;
    logic [5:0]        fw;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] fmask;
    logic [SLOT_W:0]   ppw;

    always_comb begin
        direct  = (code >= BPP_CODE_16);
        lg      = direct ? LG_W'(PIX_LG) : LG_W'(code[1:0]);
        shamt   = slot << lg;
        shifted = word >> shamt;
        fw      = 6'd1 << lg;
        fmask   = ~({WORD_W{1'b1}} << fw);
        index   = shifted[AW-1:0] & fmask[AW-1:0];
        raw     = shifted[PIX_W-1:0] & fmask[PIX_W-1:0];
        ppw     = PPW_MAX >> lg;
        last    = ({1'b0, slot} == (ppw - (SLOT_W + 1)'(1)));
    end
endmodule

// File: rtl/lcd_load_seq.sv
`timescale 1ns/1ps
module lcd_load_seq #(
    parameter int WORD_W        = 32,
    parameter int PAL_DEPTH     = 256,
    parameter int COLOR_W       = 12,
    parameter int PIX_W         = 16,
    parameter int SMALL_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        load_mode,
    input  logic              pal_clr,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              pix_ready,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic              pal_loaded
);
    import lcdseq_pkg::*;

    localparam int AW     = $clog2(PAL_DEPTH);
    localparam int CNT_W  = AW + 1;
    localparam int SLOT_W = $clog2(WORD_W);
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        sq_state_e         state;
        logic [1:0]        mode;
        logic [3:0]        code;
        logic [CNT_W-1:0]  wcnt;
        logic              have_word;
        logic [WORD_W-1:0] word;
        logic [SLOT_W-1:0] slot;
        logic              pvalid;
        logic [PIX_W-1:0]  pdata;
        logic              loaded;
    } seq_t;

    seq_t r_d, r_q;

    logic [3:0]         sz_code;
    logic [CNT_W-1:0]   kept, words;
    logic [CNT_W-1:0]   lo_idx, hi_idx;
    logic               accept, out_free, adv;
    logic               we_lo, we_hi;
    logic [COLOR_W-1:0] rdata;
    logic [AW-1:0]      pix_index;
    logic [PIX_W-1:0]   pix_raw;
    logic               pix_direct, pix_last;

    assign sz_code = (r_q.wcnt == '0) ? in_data[HALF_W-1 -: 4] : r_q.code;

    lcdseq_pal_sizer #(
        .PAL_DEPTH(PAL_DEPTH), .SMALL_ENTRIES(SMALL_ENTRIES), .CNT_W(CNT_W)
    ) u_sizer (
        .code(sz_code), .kept(kept), .words(words)
    );

    lcdseq_unpack #(
        .WORD_W(WORD_W), .PIX_W(PIX_W), .AW(AW), .SLOT_W(SLOT_W)
    ) u_unpack (
        .word(r_q.word), .slot(r_q.slot), .code(r_q.code),
        .index(pix_index), .raw(pix_raw), .direct(pix_direct), .last(pix_last)
    );

    lcdseq_pal_ram #(
        .DEPTH(PAL_DEPTH), .COLOR_W(COLOR_W), .AW(AW)
    ) u_ram (
        .clk(clk),
        .we_a(we_lo), .addr_a(lo_idx[AW-1:0]), .data_a(in_data[COLOR_W-1:0]),
        .we_b(we_hi), .addr_b(hi_idx[AW-1:0]), .data_b(in_data[HALF_W+COLOR_W-1:HALF_W]),
        .raddr(pix_index), .rdata(rdata)
    );

    always_comb begin
        out_free = !r_q.pvalid || pix_ready;
        in_ready = enable && ((r_q.state == SQ_PAL) ||
                   (r_q.state == SQ_FRAME && !r_q.have_word && out_free));
        accept   = in_valid && in_ready;
        adv      = (r_q.state == SQ_FRAME) && r_q.have_word && out_free;
        lo_idx   = {r_q.wcnt[CNT_W-2:0], 1'b0};
        hi_idx   = {r_q.wcnt[CNT_W-2:0], 1'b1};
        we_lo    = (r_q.state == SQ_PAL) && accept && (lo_idx < kept);
        we_hi    = (r_q.state == SQ_PAL) && accept && (hi_idx < kept);

        r_d = r_q;
        if (r_q.pvalid && pix_ready) r_d.pvalid = 1'b0;
        if (r_q.loaded && pal_clr && r_q.mode == LM_PAL) r_d.loaded = 1'b0;

        case (r_q.state)
            SQ_IDLE: begin
                if (enable) begin
                    r_d.mode = load_mode;
                    r_d.wcnt = '0;
                    if (load_mode == LM_PAL || load_mode == LM_BOTH) r_d.state = SQ_PAL;
                    else if (load_mode == LM_FRAME)                  r_d.state = SQ_FRAME;
                end
            end
            SQ_PAL: begin
                if (accept) begin
                    if (r_q.wcnt == '0) r_d.code = in_data[HALF_W-1 -: 4];
                    r_d.wcnt = r_q.wcnt + CNT_W'(1);
                    if (r_q.wcnt == words - CNT_W'(1)) begin
                        r_d.loaded = 1'b1;
                        r_d.state  = (r_q.mode == LM_BOTH) ? SQ_FRAME : SQ_HOLD;
                    end
                end
            end
            SQ_FRAME: begin
                if (accept) begin
                    r_d.word      = in_data;
                    r_d.have_word = 1'b1;
                    r_d.slot      = '0;
                end
                if (adv) begin
                    r_d.pvalid = 1'b1;
                    r_d.pdata  = pix_direct ? pix_raw
                                            : {{(PIX_W-COLOR_W){1'b0}}, rdata};
                    if (pix_last) r_d.have_word = 1'b0;
                    else          r_d.slot = r_q.slot + SLOT_W'(1);
                end
            end
            default: ;
        endcase

        if (!enable) begin
            r_d.state     = SQ_IDLE;
            r_d.have_word = 1'b0;
            r_d.pvalid    = 1'b0;
            r_d.loaded    = 1'b0;
            r_d.wcnt      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= SQ_IDLE;
            r_q.code      <= BPP_CODE_16;
        end else begin
            r_q <= r_d;
        end
    end

    assign pix_valid  = r_q.pvalid;
    assign pix_data   = r_q.pdata;
    assign pal_loaded = r_q.loaded;
endmodule

// File: rtl/lcd_load_seq_chk.sv
`timescale 1ns/1ps
module lcd_load_seq_chk #(
    parameter int PIX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             pal_clr,
    input logic             in_valid,
    input logic             in_ready,
    input logic             pix_ready,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_data,
    input logic             pal_loaded
);
    p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

    p_stall_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |-> !in_ready);

    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pix_valid && !pal_loaded && !in_ready));

    p_flag_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pal_loaded) |-> $past(in_valid && in_ready && enable));

    p_flag_clear_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pal_loaded) |-> $past(!enable || pal_clr));
endmodule

bind lcd_load_seq lcd_load_seq_chk #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/sim_lcd_load_seq.sv
`timescale 1ns/1ps
module sim_lcd_load_seq;
    logic        clk = 1'b0;
    logic        rst_n, enable, pal_clr, in_valid, in_ready;
    logic        pix_ready, pix_valid, pal_loaded;
    logic [1:0]  load_mode;
    logic [31:0] in_data;
    logic [15:0] pix_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [11:0] exp_pal [256];
    logic [31:0] frame_w [8];

    always #2.5 clk = ~clk;

    lcd_load_seq u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .load_mode(load_mode),
        .pal_clr(pal_clr), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .pix_ready(pix_ready), .pix_valid(pix_valid),
        .pix_data(pix_data), .pal_loaded(pal_loaded)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] color_of(input int i, input int salt);
        return 12'((i * 37 + salt * 101 + 5) & 32'hfff);
    endfunction

    task automatic start(input logic [1:0] m);
        @(negedge clk);
        load_mode = m;
        enable    = 1'b1;
    endtask

    task automatic stop_seq();
        @(negedge clk);
        enable   = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(!pix_valid && !pal_loaded && !in_ready, "R6", {pix_valid, pal_loaded, in_ready}, 0);
    endtask

    task automatic send_word(input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    // R2/R3/R4: send a palette of nw words announcing code c, kept entries stored
    task automatic send_palette(input logic [3:0] c, input int nw, input int kept, input int salt);
        for (int k = 0; k < nw; k++) begin
            logic [15:0] lo, hi;
            lo = {(k == 0) ? c : 4'h9, color_of(2 * k, salt)};
            hi = {4'h6, color_of(2 * k + 1, salt)};
            if (k == nw - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                #1;
                chk(pal_loaded == 1'b0, "R2", 32'(pal_loaded), 0);
            end
            send_word({hi, lo});
            if (2 * k < kept)     exp_pal[2 * k]     = lo[11:0];
            if (2 * k + 1 < kept) exp_pal[2 * k + 1] = hi[11:0];
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(pal_loaded == 1'b1, "R4", 32'(pal_loaded), 1);
    endtask

    // R7/R8/R9: stream nw frame words at 2**lg bpp, optional output stalls
    task automatic run_frame(input int nw, input int lg, input bit stall, input string req);
        int ppw, total;
        ppw   = 32 >> lg;
        total = nw * ppw;
        fork
            begin
                for (int i = 0; i < nw; i++) send_word(frame_w[i]);
                @(negedge clk);
                in_valid = 1'b0;
            end
            begin
                int got = 0;
                int k = 0;
                bit prev_stall = 1'b0;
                logic [15:0] prev_data = '0;
                while (got < total) begin
                    logic [31:0] w, f, m;
                    logic [15:0] e;
                    @(negedge clk);
                    pix_ready = !(stall && (k % 3 == 1));
                    k++;
                    #1;
                    if (prev_stall)
                        chk(pix_valid && pix_data == prev_data, "R9", 32'(pix_data), 32'(prev_data));
                    if (pix_valid && !pix_ready) begin
                        chk(!in_ready, "R9", 32'(in_ready), 0);
                        prev_stall = 1'b1;
                        prev_data  = pix_data;
                    end else begin
                        prev_stall = 1'b0;
                    end
                    if (pix_valid && pix_ready) begin
                        w = frame_w[got / ppw];
                        m = (lg == 4) ? 32'hffff : ((32'd1 << (1 << lg)) - 1);
                        f = (w >> ((got % ppw) << lg)) & m;
                        e = (lg == 4) ? f[15:0] : {4'h0, exp_pal[f[7:0]]};
                        chk(pix_data == e, req, 32'(pix_data), 32'(e));
                        got++;
                    end
                end
                @(negedge clk);
                pix_ready = 1'b1;
            end
        join
    endtask

    task automatic fill_frame(input int salt);
        for (int i = 0; i < 8; i++)
            frame_w[i] = (32'h1357_9bdf * (i + salt)) ^ (32'h2468_ace0 + 32'(i));
    endtask

    task automatic t_reset();
        #1;
        chk(!in_ready && !pix_valid && !pal_loaded, "R10", {in_ready, pix_valid, pal_loaded}, 0);
        fill_frame(1);
        start(2'd1);
        run_frame(2, 4, 1'b0, "R10");
        stop_seq();
    endtask

    task automatic t_reserved();
        start(2'd3);
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'h0000_3000;
        #1;
        chk(!in_ready, "R1", 32'(in_ready), 0);
        @(negedge clk);
        #1;
        chk(!in_ready && !pal_loaded, "R1", {in_ready, pal_loaded}, 0);
        stop_seq();
    endtask

    task automatic t_pal_only();
        start(2'd0);
        send_palette(4'd3, 129, 256, 1);
        chk(!in_ready, "R4", 32'(in_ready), 0);
        repeat (2) @(negedge clk);
        #1;
        chk(!in_ready && pal_loaded, "R4", {in_ready, pal_loaded}, 1);
        pal_clr = 1'b1;
        @(negedge clk);
        pal_clr = 1'b0;
        #1;
        chk(!pal_loaded, "R5", 32'(pal_loaded), 0);
        stop_seq();
    endtask

    task automatic t_frame8();
        fill_frame(5);
        frame_w[0] = 32'h0100_ff80;   // R3: entries 0 and 1 must not take the extra word
        start(2'd1);
        run_frame(6, 3, 1'b1, "R7");
        // one more word with output blocked: pixel appears one cycle after take
        @(negedge clk);
        pix_ready = 1'b0;
        send_word(32'h0000_0001);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(pix_valid && pix_data == {4'h0, exp_pal[1]}, "R3", 32'(pix_data), 32'({4'h0, exp_pal[1]}));
        enable = 1'b0;
        @(negedge clk);
        #1;
        chk(!pix_valid && !in_ready && !pal_loaded, "R6", {pix_valid, in_ready, pal_loaded}, 0);
        pix_ready = 1'b1;
    endtask

    task automatic t_both16();
        start(2'd2);
        send_palette(4'd4, 9, 16, 2);
        pal_clr = 1'b1;
        @(negedge clk);
        pal_clr = 1'b0;
        #1;
        chk(pal_loaded, "R5", 32'(pal_loaded), 1);
        fill_frame(7);
        run_frame(4, 4, 1'b1, "R8");
        stop_seq();
    endtask

    task automatic t_both4();
        start(2'd2);
        send_palette(4'd2, 65, 128, 3);
        fill_frame(11);
        run_frame(4, 2, 1'b1, "R7");
        stop_seq();
        // R6: depth code and palette kept across the disable
        fill_frame(13);
        start(2'd1);
        run_frame(2, 2, 1'b0, "R6");
        stop_seq();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        enable    = 1'b0;
        load_mode = 2'd0;
        pal_clr   = 1'b0;
        in_valid  = 1'b0;
        in_data   = '0;
        pix_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_pal_only();
        t_frame8();
        t_both16();
        t_both4();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule